// File: doc/BRIEF.md
# Branch Stall Fetch Controller

This block is the front end of a four-stage in-order pipeline: a fetch stage, a decode stage, a stage in which conditional branches are resolved, and one stage after it. It handles conditional branches by waiting. A branch's direction and target only become known at the end of the resolve stage. So when the instruction being fetched is flagged as a branch, the fetch stage stops issuing instructions for the next two cycles. It feeds invalid bubble slots into decode instead. In the cycle after the branch resolves, fetch restarts at the resolved address.

The instruction source returns a tag and a branch flag for the address presented on `fetch_addr` in the same cycle. The resolve logic supplies a taken flag and a target while the resolve stage holds the branch. The block shows the valid bit, tag and branch flag of every latched stage, and a running count of the bubbles it has inserted. Every branch costs exactly two bubble cycles, whether it is taken or not. Instruction execution, memory and the datapath lie outside the block.

Top module: `branch_stall_frontend`

## Requirements
- R1: Synchronous active-high reset clears the valid bit of every latched stage, loads `fetch_addr` with the reset address (default 16'h0100), sets `fetch_valid` to 1 and clears `bubble_count` to 0.
- R2: While no branch is in flight, `fetch_addr` rises by one each cycle. An instruction fetched in cycle n appears with its tag in decode (`stg_valid[0]`, `stg_tag[7:0]`) in cycle n+1, in resolve (index 1) in n+2 and in the after-resolve stage (index 2) in n+3.
- R3: When `imem_branch` is 1 in a cycle where `fetch_valid` is 1, the next two cycles have `fetch_valid` at 0 and `fetch_addr` unchanged.
- R4: Each cycle with `fetch_valid` at 0 enters decode as a slot with valid 0, and that slot moves one stage per cycle with valid 0.
- R5: When the resolve stage holds a valid branch and `res_taken` is 1, the next cycle fetches from `res_target` with `fetch_valid` at 1.
- R6: When the resolve stage holds a valid branch and `res_taken` is 0, the next cycle fetches the fall-through address (branch address plus one) with `fetch_valid` at 1.
- R7: Taken and not-taken branches both cost exactly two bubble cycles. The resolve stage holds the branch during the second of them.
- R8: `res_taken` and `res_target` have no effect on `fetch_addr` while the resolve stage does not hold a valid branch.
- R9: `imem_branch` is ignored in cycles where `fetch_valid` is 0.
- R10: `bubble_count` rises by one after every cycle with `fetch_valid` at 0 and holds otherwise.
- R11: A branch fetched in the first cycle after a redirect starts a new two-cycle stall at once, with no extra gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_tag | input | TAG_W | Tag of the instruction at `fetch_addr` |
| imem_branch | input | 1 | Instruction at `fetch_addr` is a conditional branch |
| res_taken | input | 1 | Direction of the branch in the resolve stage |
| res_target | input | ADDR_W | Target of the branch in the resolve stage |
| fetch_addr | output | ADDR_W | Address fetched this cycle |
| fetch_valid | output | 1 | Fetch issues a real instruction (0 = bubble) |
| stg_valid | output | NUM_STAGES-1 | Valid bits of decode, resolve and after-resolve stages |
| stg_tag | output | (NUM_STAGES-1)*TAG_W | Tags of those stages, decode in the low bits |
| stg_branch | output | NUM_STAGES-1 | Branch flags of those stages |
| bubble_count | output | CNT_W | Number of bubble cycles inserted since reset |

## Verification
Two functions can fall in the same cycle. One is the redirect to a resolved address. The other is detecting a new branch at fetch: the first instruction fetched after a redirect may itself be a branch. The bench provokes this twice. In one case the fall-through instruction after a not-taken branch is a branch. In the other, the taken target is a branch. A cycle-by-cycle table then checks that the new stall starts at once, that the bubble count steps by exactly two per branch, and that the redirect address is not disturbed. The table also drives `res_taken` and `res_target` while the resolve stage holds an ordinary instruction or a bubble, and checks that the fetch address ignores them.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  // Bubbles inserted per branch: one per cycle between fetch and resolve.
  function automatic int unsigned penalty_cycles(input int unsigned resolve_stage);
    return resolve_stage - 1;
  endfunction

  // Bits needed to hold the values 0..n.
  function automatic int unsigned count_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  typedef enum logic {
    SLOT_BUBBLE = 1'b0,
    SLOT_LIVE   = 1'b1
  } slot_kind_e;

endpackage

// File: rtl/bsf_fetch_ctl.sv
module bsf_fetch_ctl #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0100,
  parameter int unsigned BUBBLES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              imem_branch,
  input  logic              resolve_fire,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid,
  output logic              fetch_is_branch
);
  import bsf_pkg::*;

  localparam int unsigned SW = count_bits(BUBBLES);
  localparam logic [SW-1:0] STALL_LOAD = SW'(BUBBLES);

  logic [ADDR_W-1:0] pc_q;
  logic [SW-1:0]     stall_q;
  slot_kind_e        slot;
  logic              stall_start;
  logic              last_bubble;

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(1);
  endfunction

  // pc already points at branch+1 during the stall.
  function automatic logic [ADDR_W-1:0] redirect(input logic [ADDR_W-1:0] pc,
                                                 input logic taken,
                                                 input logic [ADDR_W-1:0] tgt);
    return taken ? tgt : pc;
  endfunction

  assign slot            = (stall_q == '0) ? SLOT_LIVE : SLOT_BUBBLE;
  assign fetch_valid     = (slot == SLOT_LIVE);
  assign fetch_is_branch = fetch_valid & imem_branch;
  assign stall_start     = fetch_is_branch;
  assign last_bubble     = (stall_q == SW'(1));
  assign fetch_addr      = pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q <= '0;
    end else if (stall_start) begin
      stall_q <= STALL_LOAD;
    end else if (stall_q != '0) begin
      stall_q <= stall_q - SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_ADDR;
    end else if (resolve_fire) begin
      pc_q <= redirect(pc_q, res_taken, res_target);
    end else if (fetch_valid) begin
      pc_q <= seq_next(pc_q);
    end
  end

  AST_BRANCH_FREEZES_FETCH: assert property (@(posedge clk) disable iff (rst)
    fetch_is_branch |=> !fetch_valid); // R3

  AST_ADDR_HELD_IN_STALL: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !resolve_fire) |=> $stable(fetch_addr)); // R3

  AST_RESOLVE_ON_LAST_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    resolve_fire |-> (last_bubble && !fetch_valid)); // R7

  AST_TAKEN_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (resolve_fire && res_taken) |=> (fetch_valid && fetch_addr == $past(res_target))); // R5

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
    (resolve_fire && !res_taken) |=> (fetch_valid && fetch_addr == $past(fetch_addr))); // R6

  AST_TARGET_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!resolve_fire && fetch_valid) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1)); // R8

  AST_BRANCH_IGNORED_IN_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !last_bubble) |=> !fetch_valid); // R9

endmodule

// File: rtl/bsf_stage_reg.sv
module bsf_stage_reg #(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_branch,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_branch
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_branch <= 1'b0;
      out_tag    <= '0;
    end else begin
      out_valid  <= in_valid;
      out_branch <= in_valid & in_branch;
      out_tag    <= in_tag;
    end
  end

  AST_BUBBLE_STAYS_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_branch)); // R4

endmodule

// File: rtl/bsf_bubble_ctr.sv
module bsf_bubble_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bubble,
  output logic [CNT_W-1:0] count
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (bubble) begin
      count <= bump(count);
    end
  end

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst)
    bubble |=> count == $past(count) + CNT_W'(1)); // R10

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bubble |=> $stable(count)); // R10

endmodule

// File: rtl/branch_stall_frontend.sv
module branch_stall_frontend #(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned TAG_W         = 8,
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned NUM_STAGES    = 4,
  parameter int unsigned RESOLVE_STAGE = 3,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h0100
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [TAG_W-1:0]                imem_tag,
  input  logic                            imem_branch,
  input  logic                            res_taken,
  input  logic [ADDR_W-1:0]               res_target,
  output logic [ADDR_W-1:0]               fetch_addr,
  output logic                            fetch_valid,
  output logic [NUM_STAGES-2:0]           stg_valid,
  output logic [(NUM_STAGES-1)*TAG_W-1:0] stg_tag,
  output logic [NUM_STAGES-2:0]           stg_branch,
  output logic [CNT_W-1:0]                bubble_count
);
  import bsf_pkg::*;

  localparam int unsigned LAT     = NUM_STAGES - 1;
  localparam int unsigned BUBBLES = penalty_cycles(RESOLVE_STAGE);
  localparam int unsigned RES_IDX = RESOLVE_STAGE - 1;

  // Chain index 0 is the fetch slot; 1..LAT are the latched stages.
  logic             ch_valid  [0:LAT];
  logic [TAG_W-1:0] ch_tag    [0:LAT];
  logic             ch_branch [0:LAT];

  logic fetch_is_branch;
  logic resolve_fire;
  logic bubble_slot;

  assign resolve_fire = ch_valid[RES_IDX] & ch_branch[RES_IDX];
  assign bubble_slot  = ~fetch_valid;

  bsf_fetch_ctl #(
    .ADDR_W    (ADDR_W),
    .RESET_ADDR(RESET_ADDR),
    .BUBBLES   (BUBBLES)
  ) u_fetch (
    .clk            (clk),
    .rst            (rst),
    .imem_branch    (imem_branch),
    .resolve_fire   (resolve_fire),
    .res_taken      (res_taken),
    .res_target     (res_target),
    .fetch_addr     (fetch_addr),
    .fetch_valid    (fetch_valid),
    .fetch_is_branch(fetch_is_branch)
  );

  assign ch_valid[0]  = fetch_valid;
  assign ch_tag[0]    = imem_tag;
  assign ch_branch[0] = fetch_is_branch;

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    bsf_stage_reg #(.TAG_W(TAG_W)) u_reg (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (ch_valid[i]),
      .in_tag    (ch_tag[i]),
      .in_branch (ch_branch[i]),
      .out_valid (ch_valid[i+1]),
      .out_tag   (ch_tag[i+1]),
      .out_branch(ch_branch[i+1])
    );
    assign stg_valid[i]                = ch_valid[i+1];
    assign stg_tag[i*TAG_W +: TAG_W]   = ch_tag[i+1];
    assign stg_branch[i]               = ch_branch[i+1];
  end

  bsf_bubble_ctr #(.CNT_W(CNT_W)) u_bubbles (
    .clk   (clk),
    .rst   (rst),
    .bubble(bubble_slot),
    .count (bubble_count)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (stg_valid == '0 && fetch_valid && fetch_addr == RESET_ADDR && bubble_count == '0)); // R1

  AST_DECODE_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (stg_valid[0] && stg_tag[TAG_W-1:0] == $past(imem_tag))); // R2

  AST_NO_FETCH_DURING_RESOLVE: assert property (@(posedge clk) disable iff (rst)
    resolve_fire |-> !fetch_valid); // R7

  AST_REDIRECT_MAY_RESTALL: assert property (@(posedge clk) disable iff (rst)
    ($past(resolve_fire) && fetch_is_branch) |=> !fetch_valid); // R11

endmodule

// File: tb/branch_stall_frontend_test.sv
`timescale 1ns/1ps
module branch_stall_frontend_test;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned TAG_W  = 8;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned LAT    = 3;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [TAG_W-1:0]      imem_tag;
  logic                  imem_branch = 1'b0;
  logic                  res_taken = 1'b0;
  logic [ADDR_W-1:0]     res_target = '0;
  logic [ADDR_W-1:0]     fetch_addr;
  logic                  fetch_valid;
  logic [LAT-1:0]        stg_valid;
  logic [LAT*TAG_W-1:0]  stg_tag;
  logic [LAT-1:0]        stg_branch;
  logic [CNT_W-1:0]      bubble_count;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  // Instruction source: the tag is the low byte of the address.
  assign imem_tag = fetch_addr[TAG_W-1:0];

  branch_stall_frontend uut (
    .clk(clk), .rst(rst), .imem_tag(imem_tag), .imem_branch(imem_branch),
    .res_taken(res_taken), .res_target(res_target), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .stg_valid(stg_valid), .stg_tag(stg_tag),
    .stg_branch(stg_branch), .bubble_count(bubble_count)
  );

  typedef struct packed {
    logic        br;
    logic        tk;
    logic [15:0] tgt;
    logic [15:0] addr;
    logic        fv;
    logic [2:0]  v;     // {after, resolve, decode}
    logic [7:0]  bub;
    logic [3:0]  req;
  } row_t;

  localparam int NROWS = 18;
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 1'b0, 16'h0000, 16'h0100, 1'b1, 3'b000, 8'd0, 4'd0},
    '{1'b0, 1'b0, 16'h0000, 16'h0101, 1'b1, 3'b001, 8'd0, 4'd1},
    '{1'b1, 1'b0, 16'h0000, 16'h0102, 1'b1, 3'b011, 8'd0, 4'd1},
    '{1'b1, 1'b1, 16'hBEEF, 16'h0103, 1'b0, 3'b111, 8'd0, 4'd2},
    '{1'b0, 1'b1, 16'h0200, 16'h0103, 1'b0, 3'b110, 8'd1, 4'd3},
    '{1'b0, 1'b0, 16'h0000, 16'h0200, 1'b1, 3'b100, 8'd2, 4'd4},
    '{1'b0, 1'b0, 16'h0000, 16'h0201, 1'b1, 3'b001, 8'd2, 4'd1},
    '{1'b1, 1'b0, 16'h0000, 16'h0202, 1'b1, 3'b011, 8'd2, 4'd1},
    '{1'b0, 1'b1, 16'h0777, 16'h0203, 1'b0, 3'b111, 8'd2, 4'd5},
    '{1'b0, 1'b0, 16'h0555, 16'h0203, 1'b0, 3'b110, 8'd3, 4'd7},
    '{1'b1, 1'b0, 16'h0000, 16'h0203, 1'b1, 3'b100, 8'd4, 4'd6},
    '{1'b0, 1'b0, 16'h0000, 16'h0204, 1'b0, 3'b001, 8'd4, 4'd3},
    '{1'b0, 1'b1, 16'h0300, 16'h0204, 1'b0, 3'b010, 8'd5, 4'd5},
    '{1'b1, 1'b0, 16'h0000, 16'h0300, 1'b1, 3'b100, 8'd6, 4'd8},
    '{1'b0, 1'b1, 16'h0999, 16'h0301, 1'b0, 3'b001, 8'd6, 4'd8},
    '{1'b0, 1'b0, 16'h0000, 16'h0301, 1'b0, 3'b010, 8'd7, 4'd7},
    '{1'b0, 1'b0, 16'h0000, 16'h0301, 1'b1, 3'b100, 8'd8, 4'd6},
    '{1'b0, 1'b0, 16'h0000, 16'h0302, 1'b1, 3'b001, 8'd8, 4'd9}
  };

  function automatic string req_name(input logic [3:0] code);
    case (code)
      4'd0:    return "R1";
      4'd1:    return "R2";
      4'd2:    return "R8 R9";
      4'd3:    return "R3 R4";
      4'd4:    return "R5";
      4'd5:    return "R3 R8";
      4'd6:    return "R6 R7";
      4'd7:    return "R7";
      4'd8:    return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // Table walk: inputs set at the falling edge, outputs sampled just after.
    for (int r = 0; r < NROWS; r++) begin
      imem_branch = TBL[r].br;
      res_taken   = TBL[r].tk;
      res_target  = TBL[r].tgt;
      #0.5;
      chk(req_name(TBL[r].req), $sformatf("row %0d fetch_addr", r), 32'(fetch_addr), 32'(TBL[r].addr));
      chk(req_name(TBL[r].req), $sformatf("row %0d fetch_valid", r), 32'(fetch_valid), 32'(TBL[r].fv));
      chk(req_name(TBL[r].req), $sformatf("row %0d stg_valid", r), 32'(stg_valid), 32'(TBL[r].v));
      chk("R10", $sformatf("row %0d bubble_count", r), 32'(bubble_count), 32'(TBL[r].bub));
      if (r > 0 && TBL[r].v[0])
        chk("R2", $sformatf("row %0d decode tag", r), 32'(stg_tag[TAG_W-1:0]), 32'(TBL[r-1].addr[7:0]));
      @(posedge clk);
      @(negedge clk);
    end

    // Reset in the middle of a stall returns the reset state (R1).
    imem_branch = 1'b1;
    res_taken   = 1'b0;
    @(posedge clk);
    @(negedge clk);
    imem_branch = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    chk("R1", "fetch_addr after reset", 32'(fetch_addr), 32'h0100);
    chk("R1", "fetch_valid after reset", 32'(fetch_valid), 32'd1);
    chk("R1", "stg_valid after reset", 32'(stg_valid), 32'd0);
    chk("R1", "bubble_count after reset", 32'(bubble_count), 32'd0);

    // Instruction fetched at 0100 reaches the after-resolve stage three cycles on (R2).
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    #0.5;
    chk("R2", "after-stage tag", 32'(stg_tag[2*TAG_W +: TAG_W]), 32'h00);
    chk("R2", "resolve-stage tag", 32'(stg_tag[TAG_W +: TAG_W]), 32'h01);
    chk("R2", "fetch_addr after three cycles", 32'(fetch_addr), 32'h0103);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule